// File: doc/BRIEF.md
# Cascaded FIFO Slice Token Controller

This block is the ownership logic inside one slice of a FIFO that is built by chaining identical slices into a deeper queue. Each slice carries two tokens. The write token gives the slice the right to accept the next word from the shared write port. The read token gives it the right to supply the next word to the shared read port. The block tracks the slice's local write and read locations. It qualifies the shared requests against its token and its local full and empty flags, and drives the storage strobes and addresses. When the slice uses its final location in either direction, the block hands the matching token on to the next slice.

The slices are connected in a closed ring. Each write hand-off output goes to the write hand-off input of the next slice, and each read hand-off output goes to the next read hand-off input. The last slice feeds the first one. A strap input chosen at build time marks the head slice, and that slice owns both tokens when reset ends. A hand-off output is a single-cycle combinational strobe. The receiving slice takes the token on the same clock edge on which the sender releases it, so ownership never has a gap or an overlap. The shared output bus is driven only by the slice that owns the read token. The storage array and the per-slice occupancy flags are outside this block.

Top module: `cascade_token_ctrl`

## Requirements
- R1: While reset is active, and on the first cycle after it, a slice whose head strap `head_n` is 0 owns both tokens. A slice with the strap at 1 owns neither. Both local addresses read 0.
- R2: `wr_en` is 1 exactly when `wr_req` is 1, the slice owns the write token and `loc_full` is 0. Each such cycle advances `wr_addr` by one, and it wraps from DEPTH-1 to 0.
- R3: `rd_en` is 1 exactly when `rd_req` is 1, the slice owns the read token and `loc_empty` is 0. Each such cycle advances `rd_addr` by one, and it wraps from DEPTH-1 to 0.
- R4: `wr_xout` is 1 only during a cycle in which `wr_en` is 1 and `wr_addr` is DEPTH-1. On that clock edge the slice releases the write token, unless `wr_xin` is also 1.
- R5: `rd_xout` is 1 only during a cycle in which `rd_en` is 1 and `rd_addr` is DEPTH-1. On that clock edge the slice releases the read token, unless `rd_xin` is also 1.
- R6: A slice that samples `wr_xin` (or `rd_xin`) at 1 on a clock edge owns the write (or read) token from that edge on.
- R7: `q_drive` is 1 exactly when `out_en` is 1 and the slice owns the read token.
- R8: In a ring of slices with DEPTH 2 or more, exactly one slice owns the write token and exactly one owns the read token in every cycle.
- R9: In a ring, words leave the shared read port in the order in which they were written, including across slice boundaries.
- R10: A slice that does not own a token ignores the shared request for that direction. Its strobe stays 0 and its address for that direction stays unchanged.
- R11: A write while the owning slice is full, or a read while the owning slice is empty, has no effect: no strobe, no hand-off, no change of address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_n | input | 1 | Strap; 0 marks the slice that owns both tokens after reset |
| wr_req | input | 1 | Shared write request |
| rd_req | input | 1 | Shared read request |
| loc_full | input | 1 | This slice's storage holds DEPTH words |
| loc_empty | input | 1 | This slice's storage holds no words |
| out_en | input | 1 | Shared output-drive request |
| wr_xin | input | 1 | Write token arriving from the previous slice |
| rd_xin | input | 1 | Read token arriving from the previous slice |
| wr_en | output | 1 | Write strobe to the local storage |
| wr_addr | output | $clog2(DEPTH) | Local write location |
| rd_en | output | 1 | Read strobe to the local storage |
| rd_addr | output | $clog2(DEPTH) | Local read location |
| wr_xout | output | 1 | Write token passed to the next slice |
| rd_xout | output | 1 | Read token passed to the next slice |
| wr_tok | output | 1 | Slice owns the write token |
| rd_tok | output | 1 | Slice owns the read token |
| q_drive | output | 1 | Slice drives the shared output bus |

## Verification
The two hand-offs can happen in the same cycle. One slice passes the write token while another passes the read token, so two ownership changes move around the ring on one edge. To provoke this, the bench fills a three-slice ring of depth 8 and then drains exactly one slice's worth of words. It then streams reads and writes together on every cycle, so both pointers reach the last location of their own slices in the same cycle. The bench judges the result against its own count of words written and read. It checks which slice must own each token, which slice strobes at which address, and that the word order on the shared bus is unbroken across both boundaries.

// File: rtl/casc_pkg.sv
package casc_pkg;

  // True when loc is the final physical location of a slice of the given depth.
  function automatic bit is_final_loc(input int unsigned loc, input int unsigned depth);
    return loc == depth - 1;
  endfunction

  // Location that follows loc, wrapping at the end of the slice.
  function automatic int unsigned next_loc(input int unsigned loc, input int unsigned depth);
    return is_final_loc(loc, depth) ? 0 : loc + 1;
  endfunction

endpackage

// File: rtl/casc_token.sv
module casc_token (
  input  logic clk,
  input  logic rst_n,
  input  logic own_at_reset,
  input  logic take,
  input  logic give,
  output logic own
);
  // A token arriving on the same edge as the own release keeps ownership
  // (single-slice ring where the strobe loops back to itself).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    own <= own_at_reset;
    else if (take) own <= 1'b1;
    else if (give) own <= 1'b0;
  end
endmodule

// File: rtl/casc_ptr.sv
module casc_ptr
  import casc_pkg::*;
#(
  parameter int unsigned DEPTH = 8192,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          own,
  input  logic          blocked,
  output logic          fire,
  output logic          wrap,
  output logic [AW-1:0] loc
);
  assign fire = req && own && !blocked;
  assign wrap = fire && is_final_loc(int'(loc), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    loc <= '0;
    else if (fire) loc <= AW'(next_loc(int'(loc), DEPTH));
  end
endmodule

// File: rtl/cascade_token_ctrl.sv
module cascade_token_ctrl #(
  parameter int unsigned DEPTH = 8192,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          head_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          loc_full,
  input  logic          loc_empty,
  input  logic          out_en,
  input  logic          wr_xin,
  input  logic          rd_xin,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          wr_xout,
  output logic          rd_xout,
  output logic          wr_tok,
  output logic          rd_tok,
  output logic          q_drive
);
  // Named internal events, visible to the bound checker.
  logic wr_fire, wr_wrap, rd_fire, rd_wrap;
  logic is_head;

  assign is_head = !head_n;

  // Write side
  casc_token u_wtok (
    .clk(wclk), .rst_n(rst_n), .own_at_reset(is_head),
    .take(wr_xin), .give(wr_wrap), .own(wr_tok)
  );

  casc_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(wclk), .rst_n(rst_n), .req(wr_req), .own(wr_tok),
    .blocked(loc_full), .fire(wr_fire), .wrap(wr_wrap), .loc(wr_addr)
  );

  // Read side
  casc_token u_rtok (
    .clk(rclk), .rst_n(rst_n), .own_at_reset(is_head),
    .take(rd_xin), .give(rd_wrap), .own(rd_tok)
  );

  casc_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(rclk), .rst_n(rst_n), .req(rd_req), .own(rd_tok),
    .blocked(loc_empty), .fire(rd_fire), .wrap(rd_wrap), .loc(rd_addr)
  );

  assign wr_en   = wr_fire;
  assign rd_en   = rd_fire;
  assign wr_xout = wr_wrap;
  assign rd_xout = rd_wrap;
  assign q_drive = out_en && rd_tok;
endmodule

// File: rtl/cascade_token_ctrl_chk.sv
module cascade_token_ctrl_chk #(
  parameter int unsigned DEPTH = 8192,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          loc_full,
  input logic          loc_empty,
  input logic          wr_xin,
  input logic          rd_xin,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic          wr_wrap,
  input logic          rd_wrap,
  input logic          wr_tok,
  input logic          rd_tok,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic          q_drive
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assert_wr_gate_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_fire |-> (wr_tok && !loc_full));
  assert_rd_gate_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_fire |-> (rd_tok && !loc_empty));
  assert_wr_handoff_at_end_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_wrap |-> (wr_fire && wr_addr == LAST));
  assert_wr_release_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_wrap && !wr_xin) |=> (!wr_tok && wr_addr == '0));
  assert_rd_handoff_at_end_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_wrap |-> (rd_fire && rd_addr == LAST));
  assert_rd_release_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_wrap && !rd_xin) |=> (!rd_tok && rd_addr == '0));
  assert_wr_take_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_xin |=> wr_tok);
  assert_rd_take_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_xin |=> rd_tok);
  assert_drive_owner_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    q_drive |-> rd_tok);
  assert_wr_idle_stable_R10: assert property (@(posedge wclk) disable iff (!rst_n)
    !wr_fire |=> $stable(wr_addr));
  assert_rd_idle_stable_R10: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_addr));
endmodule

bind cascade_token_ctrl cascade_token_ctrl_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/cascade_token_ctrl_bench.sv
module cascade_token_ctrl_bench;
  localparam int NS = 3;
  localparam int DP = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0, out_en = 1'b1;
  logic [15:0] wdata = '0;
  int head = 0;

  logic [NS-1:0] head_n, loc_full, loc_empty, wr_xin, rd_xin;
  logic [NS-1:0] wr_en, rd_en, wr_xout, rd_xout, wr_tok, rd_tok, q_drive;
  logic [AW-1:0] wa [NS];
  logic [AW-1:0] ra [NS];
  logic [15:0]   mem [NS][DP];
  logic [3:0]    cnt [NS];
  logic [15:0]   bus;

  int checks = 0, fails = 0;
  int wcnt = 0, rcnt = 0;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    assign head_n[s]    = (s != head);
    assign wr_xin[s]    = wr_xout[(s + NS - 1) % NS];
    assign rd_xin[s]    = rd_xout[(s + NS - 1) % NS];
    assign loc_full[s]  = (cnt[s] == 4'(DP));
    assign loc_empty[s] = (cnt[s] == 4'd0);

    cascade_token_ctrl #(.DEPTH(DP)) u_cascade_token_ctrl (
      .wclk(clk), .rclk(clk), .rst_n(rst_n), .head_n(head_n[s]),
      .wr_req(wr_req), .rd_req(rd_req), .loc_full(loc_full[s]),
      .loc_empty(loc_empty[s]), .out_en(out_en),
      .wr_xin(wr_xin[s]), .rd_xin(rd_xin[s]),
      .wr_en(wr_en[s]), .wr_addr(wa[s]), .rd_en(rd_en[s]), .rd_addr(ra[s]),
      .wr_xout(wr_xout[s]), .rd_xout(rd_xout[s]),
      .wr_tok(wr_tok[s]), .rd_tok(rd_tok[s]), .q_drive(q_drive[s])
    );

    // Behavioural slice storage, bench only.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[s] <= '0;
      else        cnt[s] <= cnt[s] + 4'(wr_en[s]) - 4'(rd_en[s]);
    end
    always_ff @(posedge clk) if (wr_en[s]) mem[s][wa[s]] <= wdata;
  end

  always_comb begin
    bus = '0;
    for (int s = 0; s < NS; s++) if (q_drive[s]) bus = bus | mem[s][ra[s]];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One cycle of stimulus; every expectation is derived from word counts.
  task automatic step(input bit wq, input bit rq, input bit oe);
    int occ, hw, hr;
    bit wacc, racc;
    logic [NS-1:0] ew, er, exw, exr;
    @(negedge clk);
    wr_req = wq; rd_req = rq; out_en = oe; wdata = 16'hA000 + 16'(wcnt);
    #1;
    occ  = wcnt - rcnt;
    hw   = (head + wcnt / DP) % NS;
    hr   = (head + rcnt / DP) % NS;
    wacc = wq && occ < NS * DP;
    racc = rq && occ > 0;
    ew   = wacc ? NS'(1 << hw) : '0;
    er   = racc ? NS'(1 << hr) : '0;
    exw  = (wacc && wcnt % DP == DP - 1) ? ew : '0;
    exr  = (racc && rcnt % DP == DP - 1) ? er : '0;
    chk(wr_tok == NS'(1 << hw), "R8 write token owner", int'(wr_tok), 1 << hw);
    chk(rd_tok == NS'(1 << hr), "R8 read token owner", int'(rd_tok), 1 << hr);
    chk(wr_en == ew, "R2/R11 write strobe", int'(wr_en), int'(ew));
    chk(rd_en == er, "R3/R11 read strobe", int'(rd_en), int'(er));
    chk(wr_xout == exw, "R4 write hand-off", int'(wr_xout), int'(exw));
    chk(rd_xout == exr, "R5 read hand-off", int'(rd_xout), int'(exr));
    chk(q_drive == (oe ? NS'(1 << hr) : '0), "R7 bus drive", int'(q_drive),
        oe ? (1 << hr) : 0);
    for (int s = 0; s < NS; s++) begin
      chk(int'(wa[s]) == ((s == hw) ? wcnt % DP : 0), "R10 write address",
          int'(wa[s]), (s == hw) ? wcnt % DP : 0);
      chk(int'(ra[s]) == ((s == hr) ? rcnt % DP : 0), "R10 read address",
          int'(ra[s]), (s == hr) ? rcnt % DP : 0);
    end
    if (racc && oe)
      chk(bus == 16'hA000 + 16'(rcnt), "R9 read order", int'(bus), 'hA000 + rcnt);
    @(posedge clk);
    if (wacc) wcnt++;
    if (racc) rcnt++;
  endtask

  task automatic do_reset(input int h);
    @(negedge clk);
    rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0; head = h;
    repeat (3) @(negedge clk);
    wcnt = 0; rcnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state(input int h);
    do_reset(h);
    #1;
    chk(wr_tok == NS'(1 << h), "R1 write token after reset", int'(wr_tok), 1 << h);
    chk(rd_tok == NS'(1 << h), "R1 read token after reset", int'(rd_tok), 1 << h);
    for (int s = 0; s < NS; s++)
      chk(wa[s] == '0 && ra[s] == '0, "R1 addresses after reset",
          int'(wa[s]) * 8 + int'(ra[s]), 0);
  endtask

  task automatic t_read_empty();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1);      // R11 empty
  endtask

  task automatic t_fill_past_full();
    for (int i = 0; i < NS * DP + 2; i++) step(1'b1, 1'b0, 1'b1);  // R2 R4 R6 R11
  endtask

  task automatic t_drain_one_slice();
    for (int i = 0; i < DP; i++) begin
      step(1'b0, 1'b1, 1'b1);                                 // R3 R5
      step(1'b0, 1'b0, 1'b0);                                 // R7 drive off
    end
  endtask

  task automatic t_concurrent_handoffs();
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b1);     // R8 R9 same-cycle
  endtask

  task automatic t_drain_all();
    while (wcnt != rcnt) step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);                                   // R11 empty again
  endtask

  task automatic t_other_head();
    t_reset_state(2);                                         // R1 different head
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1);
    t_drain_all();
  endtask

  initial begin
    t_reset_state(0);
    t_read_empty();
    t_fill_past_full();
    t_drain_one_slice();
    t_concurrent_handoffs();
    t_drain_all();
    t_other_head();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule